// File: doc/BRIEF.md
# Multiply-Accumulate Execute Unit

This unit takes one 32-bit instruction word, tagged with one of two encoding formats, and carries out a multiply-accumulate. It decodes the three source register numbers and the destination register number. It reads the operands from a register file whose read ports return data one cycle after the address is presented. It then forms the product of the first two operands plus the third and writes the low 32 bits back through a single write port. A separate condition-passed input, already evaluated upstream, gates every architectural side effect.

Each instruction produces its outcome exactly three cycles after it is presented, whatever the operand values are. The unit accepts a new instruction on every cycle. The outcome is a register write, or one of three reports: the word does not match either fixed bit pattern, the register choice is unpredictable, or the word belongs to the plain-multiply form. In the first format a control bit also lets the instruction update the negative and zero flags. The carry and overflow flags are held unchanged.

Top module: `mac_exec_unit`

## Requirements
- R1: The written data equals (Rn * Rm + Ra) mod 2^32. The value is the same whether the operands are read as signed or unsigned, and a sum that wraps to exactly zero is written as zero.
- R2: Take the cycle in which `in_valid` is sampled high as cycle 0. The write or the report for that instruction is visible in cycle 3, for one cycle. Instructions may be issued on consecutive cycles, and each keeps its own 3-cycle slot.
- R3: Format A (`in_fmt`=0) requires bits 31:28 != 4'hF, bits 27:21 = 7'b0000001 and bits 7:4 = 4'b1001. Its fields are: flag-update bit at 20, destination at 19:16, addend at 15:12, multiplier at 11:8, multiplicand at 3:0. A word that fails the pattern raises `rpt_illegal` and causes no write.
- R4: Format B (`in_fmt`=1) requires bits 31:20 = 12'hFB0 and bits 7:4 = 4'b0000. Its fields are: multiplicand at 19:16, addend at 15:12, destination at 11:8, multiplier at 3:0. A word that fails the pattern raises `rpt_illegal` and causes no write.
- R5: A format B word that matches its pattern and has addend field 4'hF raises `rpt_mul`. It causes no write and is not reported as unpredictable.
- R6: Register 15 in any of the four fields is unpredictable in format A. In format B only the destination, multiplicand and multiplier fields are checked, and register 13 is legal. An unpredictable word raises `rpt_unpred` and causes no write and no flag change.
- R7: A format A write with bit 20 set updates the flags in the same cycle as the write. N takes data bit 31, and Z is 1 exactly when the 32-bit result is zero. Format B never changes a flag, and C and V never change.
- R8: When `cond_pass` is low with the instruction, nothing is written and no flag changes. Reports for illegal, unpredictable or plain-multiply words still appear.
- R9: During and after reset, `wr_en` and all three reports are 0, and all four flags are 0.
- R10: In any cycle at most one of `wr_en`, `rpt_illegal`, `rpt_unpred` and `rpt_mul` is high. A pattern failure outranks the plain-multiply report, and the plain-multiply report outranks the unpredictable report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction word present this cycle |
| in_fmt | input | 1 | Encoding format: 0 = A, 1 = B |
| in_insn | input | 32 | Instruction word |
| cond_pass | input | 1 | Upstream condition check passed |
| rf_addr_n | output | 4 | Read address for the multiplicand |
| rf_addr_m | output | 4 | Read address for the multiplier |
| rf_addr_a | output | 4 | Read address for the addend |
| rf_data_n | input | 32 | Multiplicand data, one cycle after the address |
| rf_data_m | input | 32 | Multiplier data, one cycle after the address |
| rf_data_a | input | 32 | Addend data, one cycle after the address |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 4 | Destination register |
| wr_data | output | 32 | Low 32 bits of the result |
| rpt_illegal | output | 1 | Word failed its fixed-bit pattern |
| rpt_unpred | output | 1 | Unpredictable register choice |
| rpt_mul | output | 1 | Word belongs to the plain-multiply form |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag, held |
| flag_v | output | 1 | Overflow flag, held |

## Verification
The register write and the N/Z flag update of a flag-setting format A word land on the same clock edge. The bench checks both in that one cycle. A result that wraps to exactly zero must show zero data and Z=1 together. A format B word issued right behind it must leave both flags untouched even when its own result is zero. The stream also issues words back to back, so that one word's report falls in the cycle after another's write. The per-cycle model judges every cycle on its own.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int INSN_W = 32;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] PC_REG = 4'hF;

  typedef enum logic { FMT_A = 1'b0, FMT_B = 1'b1 } fmt_e;

  // decoded view of one instruction word
  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src_n;
    logic [REG_AW-1:0] src_m;
    logic [REG_AW-1:0] src_a;
    logic              set_nz;
    logic              bad_pat;
    logic              unpred;
    logic              is_mul;
  } dec_t;

  // per-stage control carried down the pipe
  typedef struct packed {
    logic              wr;
    logic              upd;
    logic              ill;
    logic              unp;
    logic              mul;
    logic [REG_AW-1:0] dst;
  } ctl_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  fmt_e              fmt,
  output dec_t              dec
);
  logic pat_ok;
  logic any15;
  logic a_is15;

  always_comb begin
    dec    = '0;
    pat_ok = 1'b0;
    if (fmt == FMT_A) begin
      dec.dst    = insn[19:16];
      dec.src_a  = insn[15:12];
      dec.src_m  = insn[11:8];
      dec.src_n  = insn[3:0];
      dec.set_nz = insn[20];
      pat_ok     = (insn[31:28] != 4'hF) && (insn[27:21] == 7'b0000001) &&
                   (insn[7:4] == 4'b1001);
    end else begin
      dec.src_n  = insn[19:16];
      dec.src_a  = insn[15:12];
      dec.dst    = insn[11:8];
      dec.src_m  = insn[3:0];
      pat_ok     = (insn[31:20] == 12'hFB0) && (insn[7:4] == 4'b0000);
    end
    any15  = (dec.dst == PC_REG) || (dec.src_n == PC_REG) || (dec.src_m == PC_REG);
    a_is15 = (dec.src_a == PC_REG);
    // priority: pattern failure, then plain-multiply form, then unpredictable
    dec.bad_pat = !pat_ok;
    dec.is_mul  = pat_ok && (fmt == FMT_B) && a_is15;
    dec.unpred  = pat_ok && !dec.is_mul && (any15 || ((fmt == FMT_A) && a_is15));
    if (!pat_ok) dec.set_nz = 1'b0;
  end
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] mul_x,
  input  logic [DATA_W-1:0] mul_y,
  input  logic [DATA_W-1:0] add_z,
  output logic [DATA_W-1:0] sum
);
  // only the low half of the product reaches the result, so the
  // multiplier is sized to DATA_W; sign treatment does not matter here
  logic [DATA_W-1:0] prod_lo;

  always_comb begin
    prod_lo = mul_x * mul_y;
    sum     = prod_lo + add_z;
  end
endmodule

// File: rtl/mac_flags.sv
module mac_flags #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] res,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  logic n_q, z_q, c_q, v_q;
  logic n_d, z_d, c_d, v_d;

  always_comb begin
    n_d = n_q;
    z_d = z_q;
    c_d = c_q;
    v_d = v_q;
    if (upd) begin
      n_d = res[DATA_W-1];
      z_d = (res == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= 1'b0;
      z_q <= 1'b0;
      c_q <= 1'b0;
      v_q <= 1'b0;
    end else begin
      n_q <= n_d;
      z_q <= z_d;
      c_q <= c_d;
      v_q <= v_d;
    end
  end

  assign flag_n = n_q;
  assign flag_z = z_q;
  assign flag_c = c_q;
  assign flag_v = v_q;

  // R7: carry and overflow are never touched by an update
  a_r7_cv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> $stable({flag_c, flag_v}));
  // R7: without an update the N/Z pair holds
  a_r7_nz_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({flag_n, flag_z}));
endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_fmt,
  input  logic [INSN_W-1:0] in_insn,
  input  logic              cond_pass,
  output logic [REG_AW-1:0] rf_addr_n,
  output logic [REG_AW-1:0] rf_addr_m,
  output logic [REG_AW-1:0] rf_addr_a,
  input  logic [DATA_W-1:0] rf_data_n,
  input  logic [DATA_W-1:0] rf_data_m,
  input  logic [DATA_W-1:0] rf_data_a,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rpt_illegal,
  output logic              rpt_unpred,
  output logic              rpt_mul,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_q, rst_meta_q} <= 2'b00;
    else        {rst_sync_q, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  dec_t dec;
  mac_decode u_dec (
    .insn (in_insn),
    .fmt  (fmt_e'(in_fmt)),
    .dec  (dec)
  );

  assign rf_addr_n = dec.src_n;
  assign rf_addr_m = dec.src_m;
  assign rf_addr_a = dec.src_a;

  // stage 1 next-state: outcome decided from decode and condition
  ctl_t s1_d, s1_q, s2_q, s3_q;
  always_comb begin
    s1_d = '0;
    if (in_valid) begin
      s1_d.ill = dec.bad_pat;
      s1_d.unp = dec.unpred;
      s1_d.mul = dec.is_mul;
      s1_d.wr  = cond_pass && !dec.bad_pat && !dec.unpred && !dec.is_mul;
      s1_d.upd = s1_d.wr && dec.set_nz;
      s1_d.dst = dec.dst;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // stage 2: capture operands returned by the register file
  logic [DATA_W-1:0] opx_q, opy_q, opz_q;
  logic              ops_en;
  assign ops_en = s1_q.wr;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      opx_q <= '0;
      opy_q <= '0;
      opz_q <= '0;
    end else if (ops_en) begin
      opx_q <= rf_data_n;
      opy_q <= rf_data_m;
      opz_q <= rf_data_a;
    end
  end

  // stage 3: arithmetic result register
  logic [DATA_W-1:0] sum_c, sum_q;
  logic              sum_en;
  mac_arith #(.DATA_W(DATA_W)) u_arith (
    .mul_x (opx_q),
    .mul_y (opy_q),
    .add_z (opz_q),
    .sum   (sum_c)
  );
  assign sum_en = s2_q.wr;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)  sum_q <= '0;
    else if (sum_en)  sum_q <= sum_c;
  end

  mac_flags #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .upd    (s2_q.upd),
    .res    (sum_c),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_v (flag_v)
  );

  assign wr_en       = s3_q.wr;
  assign wr_addr     = s3_q.dst;
  assign wr_data     = sum_q;
  assign rpt_illegal = s3_q.ill;
  assign rpt_unpred  = s3_q.unp;
  assign rpt_mul     = s3_q.mul;

  // R10: one outcome per cycle at most
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0({wr_en, rpt_illegal, rpt_unpred, rpt_mul}));
  // R2: a write is preceded two cycles earlier by an operand capture
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wr_en |-> $past(ops_en, 2));
  // R8: a failed condition never schedules a write
  a_r8_cond_gate: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && !cond_pass) |=> !s1_q.wr);
  // R6: an unpredictable report leaves flags alone and writes nothing
  a_r6_unpred_quiet: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rpt_unpred |-> (!wr_en && $stable({flag_n, flag_z})));
  // R5: the plain-multiply report only comes from format B words
  a_r5_mul_from_b: assert property (@(posedge clk) disable iff (!rst_sync_q)
    s1_d.mul |-> in_fmt);
endmodule

// File: tb/mac_exec_unit_tb.sv
`timescale 1ns/1ps
module mac_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_fmt, cond_pass;
  logic [31:0] in_insn;
  logic [3:0]  rf_addr_n, rf_addr_m, rf_addr_a;
  logic [31:0] rf_data_n, rf_data_m, rf_data_a;
  logic        wr_en, rpt_illegal, rpt_unpred, rpt_mul;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        flag_n, flag_z, flag_c, flag_v;

  always #2 clk = ~clk;

  mac_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_insn(in_insn), .cond_pass(cond_pass),
    .rf_addr_n(rf_addr_n), .rf_addr_m(rf_addr_m), .rf_addr_a(rf_addr_a),
    .rf_data_n(rf_data_n), .rf_data_m(rf_data_m), .rf_data_a(rf_data_a),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rpt_illegal(rpt_illegal), .rpt_unpred(rpt_unpred), .rpt_mul(rpt_mul),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // register file model: data one cycle after the address
  logic [31:0] regs [16];
  always @(posedge clk) begin
    rf_data_n <= regs[rf_addr_n];
    rf_data_m <= regs[rf_addr_m];
    rf_data_a <= regs[rf_addr_a];
  end

  typedef struct packed {
    logic        wr, upd, ill, unp, mul;
    logic [3:0]  rd;
    logic [31:0] res;
  } exp_t;

  int    n_checks = 0, n_fails = 0;
  bit    done = 0, chk_on = 0;
  exp_t  nx, p0, p1, p2;
  string nx_tag, t0, t1, t2;
  logic  en_n, en_z;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // behavioural model of one word, straight from the requirements
  task automatic model(input bit fmt, input logic [31:0] w, input bit cp,
                       output exp_t e, output string tag);
    int rd, rn, rm, ra;
    bit ok, sf, m15, u15;
    logic [63:0] wide;
    if (!fmt) begin
      ok = (w[31:28] != 4'hF) && (w[27:24] == 4'h0) && (w[23:21] == 3'b001) && (w[7:4] == 4'h9);
      rd = w[19:16]; ra = w[15:12]; rm = w[11:8]; rn = w[3:0]; sf = w[20];
      m15 = 0;
      u15 = (rd == 15) || (rn == 15) || (rm == 15) || (ra == 15);
    end else begin
      ok = (w[31:29] == 3'b111) && (w[28:23] == 6'b110110) && (w[22:20] == 3'b000) && (w[7:4] == 4'h0);
      rn = w[19:16]; ra = w[15:12]; rd = w[11:8]; rm = w[3:0]; sf = 0;
      m15 = (ra == 15);
      u15 = (rd == 15) || (rn == 15) || (rm == 15);
    end
    wide  = {32'h0, regs[rn]} * {32'h0, regs[rm]} + {32'h0, regs[ra]};
    e     = '0;
    e.ill = !ok;
    e.mul = ok && m15;
    e.unp = ok && !m15 && u15;
    e.wr  = ok && !m15 && !u15 && cp;
    e.upd = e.wr && !fmt && sf;
    e.rd  = 4'(rd);
    e.res = wide[31:0];
    if (!ok && (m15 || u15)) tag = "R10";
    else if (!ok)            tag = fmt ? "R4" : "R3";
    else if (m15)            tag = "R5";
    else if (u15)            tag = "R6";
    else if (!cp)            tag = "R8";
    else                     tag = "R2";
  endtask

  // expected-outcome pipe and flag model
  always @(posedge clk) begin
    if (!rst_n) begin
      p0 <= '0; p1 <= '0; p2 <= '0; en_n <= 0; en_z <= 0;
      t0 <= "R9"; t1 <= "R9"; t2 <= "R9";
    end else begin
      p2 <= p1; p1 <= p0; p0 <= nx;
      t2 <= t1; t1 <= t0; t0 <= nx_tag;
      if (p1.upd) begin
        en_n <= p1.res[31];
        en_z <= (p1.res == 32'h0);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      check(wr_en == p2.wr, t2, "wr_en", 32'(wr_en), 32'(p2.wr));
      if (p2.wr) begin
        check(wr_addr == p2.rd, "R1", "wr_addr", 32'(wr_addr), 32'(p2.rd));
        check(wr_data == p2.res, "R1", "wr_data", wr_data, p2.res);
      end
      check({rpt_illegal, rpt_unpred, rpt_mul} == {p2.ill, p2.unp, p2.mul}, t2,
            "reports{ill,unp,mul}", 32'({rpt_illegal, rpt_unpred, rpt_mul}),
            32'({p2.ill, p2.unp, p2.mul}));
      check({flag_n, flag_z} == {en_n, en_z}, "R7", "flags{n,z}",
            32'({flag_n, flag_z}), 32'({en_n, en_z}));
      check({flag_c, flag_v} == 2'b00, "R7", "flags{c,v}", 32'({flag_c, flag_v}), 32'h0);
    end
  end

  task automatic issue(input bit fmt, input logic [31:0] w, input bit cp);
    exp_t  e;
    string t;
    @(negedge clk);
    model(fmt, w, cp, e, t);
    in_valid = 1; in_fmt = fmt; in_insn = w; cond_pass = cp;
    nx = e; nx_tag = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_insn = 32'h0; cond_pass = 0; nx = '0; nx_tag = "R2";
    end
  endtask

  function automatic logic [31:0] enc_a(logic [3:0] c, logic s, logic [3:0] d,
                                        logic [3:0] a, logic [3:0] m, logic [3:0] n);
    return {c, 4'b0000, 3'b001, s, d, a, m, 4'b1001, n};
  endfunction

  function automatic logic [31:0] enc_b(logic [3:0] n, logic [3:0] a,
                                        logic [3:0] d, logic [3:0] m);
    return {3'b111, 6'b110110, 3'b000, n, a, d, 2'b00, 2'b00, m};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_fmt = 0; in_insn = 0; cond_pass = 0;
    nx = '0; nx_tag = "R2";
    for (int i = 0; i < 16; i++) regs[i] = 32'(i) * 32'h0101_0101;
    repeat (3) @(negedge clk);
    // R9: reset state
    check({wr_en, rpt_illegal, rpt_unpred, rpt_mul} == 4'b0, "R9", "outputs in reset",
          32'({wr_en, rpt_illegal, rpt_unpred, rpt_mul}), 32'h0);
    check({flag_n, flag_z, flag_c, flag_v} == 4'b0, "R9", "flags in reset",
          32'({flag_n, flag_z, flag_c, flag_v}), 32'h0);
    rst_n = 1;
    idle(4);
    chk_on = 1;

    regs[1] = 32'd7;  regs[2] = 32'd6;  regs[3] = 32'd100;
    regs[4] = 32'h8000_0000; regs[5] = 32'h8000_0000; regs[0] = 32'h0;
    regs[6] = 32'hFFFF_FFFF; regs[7] = 32'd5;
    regs[8] = 32'd3; regs[9] = 32'hFFFF_FFF1;
    // R1/R3: plain format A, no flags
    issue(0, enc_a(4'hE, 0, 4'd10, 4'd3, 4'd2, 4'd1), 1);
    // R7: 0x80000000 squared plus 0 wraps to zero, Z set
    issue(0, enc_a(4'h0, 1, 4'd11, 4'd0, 4'd5, 4'd4), 1);
    // R7: -1 * 5 + 0, N set; R1 signed view
    issue(0, enc_a(4'h1, 1, 4'd12, 4'd0, 4'd7, 4'd6), 1);
    // R4/R7: format B, 3*5 + (-15) = 0 but flags untouched
    issue(1, enc_b(4'd8, 4'd9, 4'd13, 4'd7), 1);
    // R6: format B with register 13 as a source is legal
    issue(1, enc_b(4'd13, 4'd1, 4'd2, 4'd13), 1);
    // R5: format B addend field 15
    issue(1, enc_b(4'd1, 4'd15, 4'd2, 4'd3), 1);
    // R6: format A addend 15, format A destination 15, format B multiplicand 15
    issue(0, enc_a(4'hE, 1, 4'd2, 4'd15, 4'd1, 4'd3), 1);
    issue(0, enc_a(4'hE, 1, 4'd15, 4'd1, 4'd1, 4'd3), 1);
    issue(1, enc_b(4'd15, 4'd1, 4'd2, 4'd3), 1);
    // R3: cond 1111, and bad low nibble
    issue(0, enc_a(4'hF, 0, 4'd2, 4'd1, 4'd1, 4'd3), 1);
    issue(0, enc_a(4'hE, 0, 4'd2, 4'd1, 4'd1, 4'd3) ^ 32'h0000_0020, 1);
    // R4: broken fixed field; R10: broken field with addend 15
    issue(1, enc_b(4'd1, 4'd1, 4'd2, 4'd3) ^ 32'h0010_0000, 1);
    issue(1, enc_b(4'd1, 4'd15, 4'd2, 4'd3) | 32'h0000_0040, 1);
    // R8: condition failed on a flag-setting zero result
    issue(0, enc_a(4'h0, 1, 4'd11, 4'd0, 4'd5, 4'd4), 0);
    issue(1, enc_b(4'd1, 4'd15, 4'd2, 4'd3), 0);
    idle(5);

    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    regs[14] = 32'h0;
    // R2: back-to-back random stream
    for (int k = 0; k < 400; k++) begin
      bit          f = 1'($urandom);
      logic [31:0] w;
      logic [3:0]  r0 = 4'($urandom), r1 = 4'($urandom), r2 = 4'($urandom), r3 = 4'($urandom);
      if (f) w = enc_b(r0, r1, r2, r3);
      else   w = enc_a(4'($urandom), 1'($urandom), r0, r1, r2, r3);
      if ($urandom % 8 == 0) w = w ^ (32'h1 << ($urandom % 32));
      issue(f, w, ($urandom % 4) != 0);
    end
    idle(6);
    done = 1;
    summary();
    $finish;
  end
endmodule